// File: doc/BRIEF.md
# Auto-Sleep Mode Controller

This block keeps track of the operating mode of a sensing subsystem. It reports three modes as a 2-bit code: standby, wake and sleep. A run control input takes the system out of standby into wake. While the system is in wake, an inactivity counter advances on a tick strobe. When a programmed number of ticks passes with no enabled interrupt, the system drops into sleep. An interrupt on any source picked by a wake-select mask then brings it back to wake.

Both automatic transitions, wake to sleep and sleep to wake, set a sticky event flag. A read strobe on the mode register clears that flag. The block also drives a rate-select output that asks the rest of the chip for the low output data rate while asleep and the high rate otherwise. Rate generation and the sensing functions sit outside this block.

Top module: `asm_ctrl`

## Requirements
- R1: After reset, mode_o is 2'b00 (standby), low_rate_o is 0 and aslp_evt_o is 0. The mode codes are 2'b00 standby, 2'b01 wake and 2'b10 sleep, and 2'b11 never appears.
- R2: In standby with run_i high, mode_o becomes wake at the next clock edge. Whenever run_i is low at an edge, mode_o becomes standby from any mode and the event flag is not set.
- R3: In wake with autosleep_en_i high, idle_limit_i = L > 0 and no enabled interrupt, mode_o becomes sleep at the edge that samples the L-th tick_i pulse counted since the last entry into wake or the last restart.
- R4: In sleep, an irq_evt_i bit whose wake_sel_i bit is set returns mode_o to wake at the next edge. Events on unselected sources leave the mode in sleep.
- R5: In wake, any irq_evt_i bit whose irq_en_i bit is set restarts the inactivity count at zero. A tick in that same cycle is not counted. Events on sources that are not enabled do not restart the count.
- R6: low_rate_o is 1 exactly while mode_o is sleep.
- R7: Each automatic wake-to-sleep and sleep-to-wake transition sets aslp_evt_o at that same edge, and the flag stays set until it is cleared.
- R8: A mode_rd_i pulse clears aslp_evt_o at the next edge when no transition coincides.
- R9: With autosleep_en_i low the mode never becomes sleep. If the block is in sleep when autosleep_en_i goes low, it returns to wake without setting the flag.
- R10: An idle_limit_i of zero means the block never enters sleep.
- R11: When a flag-setting transition and a mode_rd_i pulse fall in the same cycle, aslp_evt_o ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run control; low forces standby |
| autosleep_en_i | input | 1 | Allows automatic entry into sleep |
| tick_i | input | 1 | Inactivity counter advance strobe |
| idle_limit_i | input | CNT_W | Quiet ticks before sleep; 0 disables sleep |
| irq_evt_i | input | N_SRC | Interrupt event pulses, one per source |
| irq_en_i | input | N_SRC | Sources whose events restart the inactivity count |
| wake_sel_i | input | N_SRC | Sources whose events wake the block from sleep |
| mode_rd_i | input | 1 | Read strobe of the mode register |
| mode_o | output | 2 | Mode code: 00 standby, 01 wake, 10 sleep |
| low_rate_o | output | 1 | 1 selects the low output data rate |
| aslp_evt_o | output | 1 | Sticky automatic transition flag |

## Verification
The bench places the sleep transition on the exact tick count and checks the L-1 tick just before it. An off-by-one counter would enter sleep one tick early or late. It fires a restart in the same cycle as a tick, which a design that counts that tick would let expire early. It also sends events on sources that are enabled for one mask but not for the other. A design that mixes up the masks would wake on the wrong source or restart on the wrong one. It lines up a transition with a read strobe, where a read-priority flag would be lost. It exercises a zero limit and a dropped auto-sleep enable, where a careless design would fall asleep immediately or stay stuck in sleep.

// File: rtl/asm_pkg.sv
package asm_pkg;

    typedef enum logic [1:0] {
        MODE_STBY  = 2'b00,
        MODE_WAKE  = 2'b01,
        MODE_SLEEP = 2'b10
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  flag;
    } fsm_state_t;

endpackage

// File: rtl/asm_idle_timer.sv
module asm_idle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SUM_W-1:0] cnt_inc;
    logic             expire;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + SUM_W'(1);
        expire  = run_i && !restart_i && tick_i && (cnt_inc >= {1'b0, limit_i});
        cnt_d   = cnt_q;
        if (!run_i || restart_i || expire) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = expire;

    // R5
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && restart_i) |=> (cnt_q == '0));

    // R10
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_i == '0) |-> !expire_o);

endmodule

// File: rtl/asm_mode_fsm.sv
module asm_mode_fsm
    import asm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_i,
    input  logic  aslp_en_i,
    input  logic  expire_i,
    input  logic  wake_hit_i,
    input  logic  mode_rd_i,
    output mode_e mode_o,
    output logic  flag_o
);
    fsm_state_t st_d, st_q;
    logic       set_evt;

    always_comb begin
        st_d    = st_q;
        set_evt = 1'b0;
        unique case (st_q.mode)
            MODE_STBY: begin
                if (run_i) st_d.mode = MODE_WAKE;
            end
            MODE_WAKE: begin
                if (!run_i) begin
                    st_d.mode = MODE_STBY;
                end else if (expire_i) begin
                    st_d.mode = MODE_SLEEP;
                    set_evt   = 1'b1;
                end
            end
            MODE_SLEEP: begin
                if (!run_i) begin
                    st_d.mode = MODE_STBY;
                end else if (!aslp_en_i) begin
                    st_d.mode = MODE_WAKE;
                end else if (wake_hit_i) begin
                    st_d.mode = MODE_WAKE;
                    set_evt   = 1'b1;
                end
            end
            default: st_d.mode = MODE_STBY;
        endcase
        if (set_evt) begin
            st_d.flag = 1'b1;
        end else if (mode_rd_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_STBY, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign flag_o = st_q.flag;

    // R2
    standby_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.mode == MODE_STBY));

    // R7
    sleep_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_WAKE && run_i && expire_i) |=> (st_q.mode == MODE_SLEEP && st_q.flag));

    // R8
    flag_fall_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(mode_rd_i));

    // R9
    no_sleep_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aslp_en_i |=> (st_q.mode != MODE_SLEEP));

endmodule

// File: rtl/asm_ctrl.sv
module asm_ctrl
    import asm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             autosleep_en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] idle_limit_i,
    input  logic [N_SRC-1:0] irq_evt_i,
    input  logic [N_SRC-1:0] irq_en_i,
    input  logic [N_SRC-1:0] wake_sel_i,
    input  logic             mode_rd_i,
    output logic [1:0]       mode_o,
    output logic             low_rate_o,
    output logic             aslp_evt_o
);
    mode_e mode;
    logic  restart, wake_hit, timer_run, expire, flag;

    always_comb begin
        restart   = |(irq_evt_i & irq_en_i);
        wake_hit  = |(irq_evt_i & wake_sel_i);
        timer_run = (mode == MODE_WAKE) && run_i && autosleep_en_i && (idle_limit_i != '0);
    end

    asm_idle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (timer_run),
        .restart_i (restart),
        .tick_i    (tick_i),
        .limit_i   (idle_limit_i),
        .expire_o  (expire)
    );

    asm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .aslp_en_i  (autosleep_en_i),
        .expire_i   (expire),
        .wake_hit_i (wake_hit),
        .mode_rd_i  (mode_rd_i),
        .mode_o     (mode),
        .flag_o     (flag)
    );

    assign mode_o     = mode;
    assign low_rate_o = (mode == MODE_SLEEP);
    assign aslp_evt_o = flag;

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

endmodule

// File: tb/asm_ctrl_test.sv
`timescale 1ns/1ps
module asm_ctrl_test;
    localparam int CW = 8;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0, aslp_en = 1'b0, tick = 1'b0, mode_rd = 1'b0;
    logic [CW-1:0] limit = '0;
    logic [NS-1:0] evt = '0, irq_en = '0, wake_sel = '0;
    logic [1:0]    mode;
    logic          low_rate, flag;

    int checks = 0;
    int errors = 0;
    logic [1:0] m_mode = 2'b00;
    int         m_cnt  = 0;
    logic       m_flag = 1'b0;

    always #10 clk = ~clk;

    asm_ctrl #(.CNT_W(CW), .N_SRC(NS)) uut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .autosleep_en_i(aslp_en),
        .tick_i(tick), .idle_limit_i(limit), .irq_evt_i(evt), .irq_en_i(irq_en),
        .wake_sel_i(wake_sel), .mode_rd_i(mode_rd),
        .mode_o(mode), .low_rate_o(low_rate), .aslp_evt_o(flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // expected next state from the requirements
    task automatic step();
        logic [1:0] n_mode = m_mode;
        int         n_cnt  = m_cnt;
        logic       n_flag = m_flag;
        logic       setf   = 1'b0;
        logic       rst_c  = |(evt & irq_en);
        logic       run_t  = (m_mode == 2'b01) && run && aslp_en && (limit != 0);
        logic       exp_t  = run_t && !rst_c && tick && (m_cnt + 1 >= int'(limit));
        if (!run) n_mode = 2'b00;
        else if (m_mode == 2'b00) n_mode = 2'b01;
        else if (m_mode == 2'b01 && exp_t) begin n_mode = 2'b10; setf = 1'b1; end
        else if (m_mode == 2'b10 && !aslp_en) n_mode = 2'b01;
        else if (m_mode == 2'b10 && |(evt & wake_sel)) begin n_mode = 2'b01; setf = 1'b1; end
        if (!run_t || rst_c || exp_t) n_cnt = 0;
        else if (tick) n_cnt = m_cnt + 1;
        if (setf) n_flag = 1'b1;
        else if (mode_rd) n_flag = 1'b0;
        @(posedge clk);
        m_mode = n_mode; m_cnt = n_cnt; m_flag = n_flag;
        #2;
    endtask

    task automatic cmp_all(input string tag);
        chk({tag, " mode"}, mode, m_mode);
        chk({tag, " R6 low_rate"}, low_rate, (m_mode == 2'b10));
        chk({tag, " flag"}, flag, m_flag);
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 low_rate", low_rate, 0);
        chk("R1 flag", flag, 0);
        // R2 standby -> wake
        run = 1; aslp_en = 1; limit = 3; wake_sel = 6'b000010; irq_en = 6'b000100;
        step(); chk("R2 to wake", mode, 1);
        // R3 sleep after exactly 3 ticks
        tick = 1;
        step(); step(); chk("R3 not yet at L-1", mode, 1);
        step(); chk("R3 sleep at L", mode, 2);
        chk("R6 low rate in sleep", low_rate, 1);
        chk("R7 flag on sleep", flag, 1);
        tick = 0;
        // R4 unselected source does not wake
        evt = 6'b000001; step(); evt = 0;
        chk("R4 unselected stays asleep", mode, 2);
        // R8 read clears
        mode_rd = 1; step(); mode_rd = 0;
        chk("R8 read clears flag", flag, 0);
        // R4 selected wakes, R7 flag
        evt = 6'b000010; step(); evt = 0;
        chk("R4 selected wakes", mode, 1);
        chk("R7 flag on wake", flag, 1);
        // R11 set and read coincide
        tick = 1; mode_rd = 1; step(); mode_rd = 0;
        chk("R8 cleared in wake", flag, 0);
        step(); mode_rd = 1; step(); mode_rd = 0;
        chk("R11 set wins mode", mode, 2);
        chk("R11 set wins flag", flag, 1);
        // R5 restart
        tick = 0; evt = 6'b000010; step(); evt = 0;
        tick = 1; step(); step();
        evt = 6'b000100; step(); evt = 0;
        chk("R5 restart keeps wake", mode, 1);
        step(); step(); chk("R5 counted from zero", mode, 1);
        evt = 6'b001000; step(); evt = 0;
        chk("R5 non-enabled source counts", mode, 2);
        cmp_all("R5 model");
        // R9 enable low leaves sleep without flag
        tick = 0; mode_rd = 1; step(); mode_rd = 0;
        aslp_en = 0; step();
        chk("R9 back to wake", mode, 1);
        chk("R9 no flag", flag, 0);
        tick = 1; repeat (10) step();
        chk("R9 never sleeps", mode, 1);
        // R10 zero limit
        aslp_en = 1; limit = 0; repeat (10) step();
        chk("R10 zero limit", mode, 1);
        // R2 stop from sleep
        limit = 1; step(); chk("R3 limit one", mode, 2);
        run = 0; step();
        chk("R2 stop to standby", mode, 0);
        chk("R6 low rate off", low_rate, 0);
        cmp_all("R2 model");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) begin
                irq_en   = NS'($urandom);
                wake_sel = NS'($urandom);
            end
            if ($urandom % 50 == 0) limit = CW'($urandom % 6);
            run     = ($urandom % 16) != 0;
            aslp_en = ($urandom % 8) != 0;
            tick    = $urandom % 2;
            evt     = ($urandom % 5 == 0) ? NS'($urandom) : '0;
            mode_rd = ($urandom % 6) == 0;
            step();
            cmp_all("R3 R4 R5 R7 R8 rand");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule